// File: doc/BRIEF.md
# Wormhole Crossbar with Grouped Adaptive Output Selection

This block is the switching core of a packet router. Each of its `NPORT` inputs carries a byte stream with valid/ready handshaking and an end-of-packet flag. The first byte of every packet is a header that selects a set of acceptable output ports. Header values 0 to 31 address one port directly. Values 32 to 255 are logical addresses, and each of them selects an entry in a routing table that software can rewrite at run time.

A logical entry names a group of redundant output links as a bitmask. Once the header is resolved, the input claims the lowest-numbered member of its group that is both idle and link-up, so a failed link is skipped without any software action. When several inputs want the same output in the same cycle, the output is granted in round-robin order. The claimed output stays bound to the input until the end-of-packet byte has been handed over. No byte is buffered inside the block.

A packet whose group holds no link-up member is consumed and thrown away up to its end-of-packet byte, and a saturating counter records each such packet.

Top module: `gar_wormhole_xbar`

## Requirements
- R1: A header value below `NPORT` routes the packet to that output port. The header byte is removed and the payload bytes appear unchanged, with end-of-packet on the last byte.
- R2: A header value from 32 to 255 reads the table entry at that value, which holds a port bitmask and a strip flag. With the strip flag at 0 the header byte is forwarded as the first output byte. A header byte that itself carries end-of-packet is always forwarded.
- R3: Among the group members that are link-up and not bound to another input, the lowest-numbered one is chosen.
- R4: A group member whose `link_up` bit is 0 is never chosen. The packet leaves on another link-up member of the same group.
- R5: An output stays bound to one input from its grant until the end-of-packet handshake on that output, and no other input's data appears on it meanwhile. An input is bound to at most one output.
- R6: Inputs that wait for the same free output are served in round-robin order. The search starts at the input after the most recent winner of that output.
- R7: A packet is discarded up to and including its end-of-packet byte, with `in_ready` held at 1, when its header selects no link-up port. This covers an empty table entry, a direct value from `NPORT` to 31, and a group whose links are all down. `drop_count` rises by one per such packet and adds all inputs that drop in the same cycle. It saturates at its maximum.
- R8: When every link-up member of a group is bound to another input, the waiting input keeps `in_ready` at 0, keeps its header, and loses no data.
- R9: A table write with `tbl_addr` below 32 has no effect. Reset empties every table entry.
- R10: After reset all `out_valid` and `in_ready` bits are 0 and `drop_count` is 0.
- R11: While a bound output has `out_ready` at 0, its input sees `in_ready` at 0 and the output holds the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Byte valid per input |
| in_data | input | NPORT*8 | Byte per input, input i at bits [8i+7:8i] |
| in_eop | input | NPORT | End-of-packet flag per input byte |
| in_ready | output | NPORT | Byte accepted per input |
| out_valid | output | NPORT | Byte valid per output |
| out_data | output | NPORT*8 | Byte per output, output o at bits [8o+7:8o] |
| out_eop | output | NPORT | End-of-packet flag per output byte |
| out_ready | input | NPORT | Downstream accepts byte per output |
| link_up | input | NPORT | Link status per output, 1 = usable |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Logical address to write (32 to 255) |
| tbl_mask | input | NPORT | Output group bitmask for that address |
| tbl_strip | input | 1 | Strip-header flag for that address |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
Two inputs can hit an unroutable header in the same clock, so the drop counter must add both events in one edge. The bench starts two such packets together on different inputs and reads the counter one edge later, expecting a rise of two. The same clock that releases an output at end-of-packet can also find several inputs waiting for it. The bench queues three inputs on a single-member group after moving that output's round-robin pointer, and checks that the order in which bytes arrive matches the pointer rather than fixed priority.

// File: rtl/gwx_pkg.sv
package gwx_pkg;

    localparam int BYTE_W       = 8;
    localparam int DIRECT_SPAN  = 32;
    localparam int LOGICAL_SPAN = 256 - DIRECT_SPAN;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_DROP = 2'd2
    } in_state_e;

    typedef struct packed {
        logic              eop;
        logic [BYTE_W-1:0] data;
    } beat_t;

    // index of the lowest set bit, 0 when none is set
    function automatic int first_one(logic [31:0] m);
        int r;
        r = 0;
        for (int b = 31; b >= 0; b--) begin
            if (m[b]) r = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/gwx_route_table.sv
module gwx_route_table
    import gwx_pkg::*;
#(
    parameter int NPORT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        waddr,
    input  logic [NPORT-1:0]  wmask,
    input  logic              wstrip,
    input  logic [7:0]        hdr      [NPORT],
    output logic [NPORT-1:0]  rt_mask  [NPORT],
    output logic              rt_strip [NPORT]
);

    logic [NPORT-1:0]        mask_q [LOGICAL_SPAN];
    logic [LOGICAL_SPAN-1:0] strip_q;
    logic [7:0]              widx;

    assign widx = waddr - 8'(DIRECT_SPAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < LOGICAL_SPAN; e++) begin
                mask_q[e] <= '0;
            end
            strip_q <= '0;
        end else if (we && (waddr >= 8'(DIRECT_SPAN))) begin
            mask_q[widx]  <= wmask;
            strip_q[widx] <= wstrip;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_look
        logic [7:0] lidx;
        assign lidx = hdr[g] - 8'(DIRECT_SPAN);

        always_comb begin
            rt_mask[g]  = '0;
            rt_strip[g] = 1'b0;
            if (hdr[g] < 8'(DIRECT_SPAN)) begin
                if (hdr[g] < 8'(NPORT)) begin
                    rt_mask[g][hdr[g][4:0]] = 1'b1;
                    rt_strip[g]             = 1'b1;
                end
            end else begin
                rt_mask[g]  = mask_q[lidx];
                rt_strip[g] = strip_q[lidx];
            end
        end
    end

endmodule

// File: rtl/gwx_input_ctrl.sv
module gwx_input_ctrl
    import gwx_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_eop,
    input  logic [NPORT-1:0] rt_mask,
    input  logic             rt_strip,
    input  logic [NPORT-1:0] link_up,
    input  logic [NPORT-1:0] out_busy,
    input  logic             gnt,
    input  logic             sel_ready,
    output logic             req,
    output logic [PW-1:0]    req_port,
    output logic [PW-1:0]    conn,
    output logic             in_ready,
    output logic             drop_evt,
    output logic             done
);

    in_state_e        st_q, st_d;
    logic [PW-1:0]    conn_q;
    logic [NPORT-1:0] avail, free;
    logic             no_route, take_hdr;

    assign avail    = rt_mask & link_up;
    assign free     = avail & ~out_busy;
    assign no_route = ~|avail;

    assign req      = (st_q == ST_IDLE) && in_valid && (|free);
    assign req_port = PW'(first_one(32'(free)));
    assign drop_evt = (st_q == ST_IDLE) && in_valid && no_route;
    assign take_hdr = gnt && rt_strip && !in_eop;
    assign done     = (st_q == ST_FWD) && in_valid && sel_ready && in_eop;
    assign conn     = conn_q;

    always_comb begin
        case (st_q)
            ST_FWD:  in_ready = sel_ready;
            ST_DROP: in_ready = 1'b1;
            default: in_ready = drop_evt || take_hdr;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (drop_evt && !in_eop) st_d = ST_DROP;
                else if (gnt)            st_d = ST_FWD;
            end
            ST_FWD:  if (done)                st_d = ST_IDLE;
            ST_DROP: if (in_valid && in_eop)  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            conn_q <= '0;
        end else begin
            st_q <= st_d;
            if (gnt) conn_q <= req_port;
        end
    end

endmodule

// File: rtl/gwx_out_arb.sv
module gwx_out_arb #(
    parameter int NPORT = 8,
    parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] done,
    output logic [NPORT-1:0] gnt,
    output logic             owns,
    output logic [PW-1:0]    owner
);

    logic [PW-1:0] ptr_q, win, owner_q;
    logic          owns_q, hit;

    always_comb begin
        gnt = '0;
        hit = 1'b0;
        win = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (!owns_q && !hit && req[(int'(ptr_q) + k) % NPORT]) begin
                hit = 1'b1;
                win = PW'((int'(ptr_q) + k) % NPORT);
            end
        end
        if (hit) gnt[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owns_q  <= 1'b0;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (owns_q) begin
            if (done[owner_q]) owns_q <= 1'b0;
        end else if (hit) begin
            owns_q  <= 1'b1;
            owner_q <= win;
            ptr_q   <= PW'((int'(win) + 1) % NPORT);
        end
    end

    assign owns  = owns_q;
    assign owner = owner_q;

endmodule

// File: rtl/gar_wormhole_xbar.sv
module gar_wormhole_xbar
    import gwx_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*BYTE_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_eop,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*BYTE_W-1:0] out_data,
    output logic [NPORT-1:0]        out_eop,
    input  logic [NPORT-1:0]        out_ready,
    input  logic [NPORT-1:0]        link_up,
    input  logic                    tbl_we,
    input  logic [7:0]              tbl_addr,
    input  logic [NPORT-1:0]        tbl_mask,
    input  logic                    tbl_strip,
    output logic [CNT_W-1:0]        drop_count
);

    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic [7:0]                  hdr      [NPORT];
    logic [NPORT-1:0]            rt_mask  [NPORT];
    logic                        rt_strip [NPORT];
    logic [NPORT-1:0]            req, gnt_in, sel_ready, drop_evt, done, owns;
    logic [NPORT-1:0][PW-1:0]    req_port, conn, owner;
    logic [NPORT-1:0][NPORT-1:0] req_to, gnt_to;
    beat_t                       in_beat  [NPORT];
    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W:0]              cnt_sum;

    gwx_route_table #(.NPORT(NPORT)) u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (tbl_we),
        .waddr    (tbl_addr),
        .wmask    (tbl_mask),
        .wstrip   (tbl_strip),
        .hdr      (hdr),
        .rt_mask  (rt_mask),
        .rt_strip (rt_strip)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign hdr[i]          = in_data[i*BYTE_W +: BYTE_W];
        assign in_beat[i].data = in_data[i*BYTE_W +: BYTE_W];
        assign in_beat[i].eop  = in_eop[i];
        assign sel_ready[i]    = out_ready[conn[i]];

        gwx_input_ctrl #(.NPORT(NPORT), .PW(PW)) u_ctl (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[i]),
            .in_eop    (in_eop[i]),
            .rt_mask   (rt_mask[i]),
            .rt_strip  (rt_strip[i]),
            .link_up   (link_up),
            .out_busy  (owns),
            .gnt       (gnt_in[i]),
            .sel_ready (sel_ready[i]),
            .req       (req[i]),
            .req_port  (req_port[i]),
            .conn      (conn[i]),
            .in_ready  (in_ready[i]),
            .drop_evt  (drop_evt[i]),
            .done      (done[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_to[o][i] = req[i] && (req_port[i] == PW'(o));
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        gwx_out_arb #(.NPORT(NPORT), .PW(PW)) u_arb (
            .clk   (clk),
            .rst   (rst),
            .req   (req_to[o]),
            .done  (done),
            .gnt   (gnt_to[o]),
            .owns  (owns[o]),
            .owner (owner[o])
        );
    end

    always_comb begin
        gnt_in = '0;
        for (int o = 0; o < NPORT; o++) begin
            gnt_in = gnt_in | gnt_to[o];
        end
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            beat_t b;
            b = in_beat[owner[o]];
            out_valid[o]                 = owns[o] && in_valid[owner[o]];
            out_eop[o]                   = owns[o] && b.eop;
            out_data[o*BYTE_W +: BYTE_W] = b.data;
        end
    end

    assign cnt_sum = {1'b0, cnt_q} + (CNT_W+1)'($countones(drop_evt));

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_sum[CNT_W]) cnt_q <= '1;
        else                   cnt_q <= cnt_sum[CNT_W-1:0];
    end

    assign drop_count = cnt_q;

endmodule

// File: rtl/gwx_chk.sv
module gwx_chk #(
    parameter int NPORT = 8,
    parameter int CNT_W = 16,
    parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [NPORT-1:0]    out_valid,
    input logic [NPORT-1:0]    out_ready,
    input logic [NPORT-1:0]    out_eop,
    input logic [NPORT-1:0]    link_up,
    input logic [NPORT-1:0]    owns,
    input logic [NPORT*PW-1:0] owner_flat,
    input logic [CNT_W-1:0]    drop_count
);

    logic [NPORT-1:0] held_by [NPORT];

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                held_by[i][o] = owns[o] && (owner_flat[o*PW +: PW] == PW'(i));
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_po
        // R5
        hold_until_eop_chk: assert property (@(posedge clk) disable iff (rst)
            owns[o] && !(out_valid[o] && out_ready[o] && out_eop[o])
            |=> owns[o] && $stable(owner_flat[o*PW +: PW]));

        // R5
        release_on_eop_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(owns[o]) |-> $past(out_valid[o] && out_ready[o] && out_eop[o]));

        // R4
        grant_link_up_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(owns[o]) |-> $past(link_up[o]));
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_pi
        // R5
        one_output_per_input_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(held_by[i]) <= 1);
    end

    // R7
    drop_count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> drop_count >= $past(drop_count));

endmodule

bind gar_wormhole_xbar gwx_chk #(.NPORT(NPORT), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_eop    (out_eop),
    .link_up    (link_up),
    .owns       (owns),
    .owner_flat (owner),
    .drop_count (drop_count)
);

// File: tb/sim_gar_wormhole_xbar.sv
module sim_gar_wormhole_xbar;

    localparam int NP = 8;
    localparam int CW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NP-1:0]  vin = '0;
    logic [NP*8-1:0] din = '0;
    logic [NP-1:0]  ein = '0;
    logic [NP-1:0]  irdy;
    logic [NP-1:0]  ovalid;
    logic [NP*8-1:0] odata;
    logic [NP-1:0]  oeop;
    logic [NP-1:0]  ordy;
    logic [NP-1:0]  link = '1;
    logic           twe = 1'b0;
    logic [7:0]     taddr = '0;
    logic [NP-1:0]  tmask = '0;
    logic           tstrip = 1'b0;
    logic [CW-1:0]  dcnt;

    logic           rand_rdy = 1'b0;
    logic [NP-1:0]  man_rdy = '1;
    logic [NP-1:0]  rnd_bits = '1;

    int checks = 0;
    int errors = 0;

    logic [8:0] rxq [NP][$];
    logic [8:0] exq [NP][$];

    always #10 clk = ~clk;

    assign ordy = rand_rdy ? rnd_bits : man_rdy;

    gar_wormhole_xbar #(.NPORT(NP), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(vin), .in_data(din), .in_eop(ein), .in_ready(irdy),
        .out_valid(ovalid), .out_data(odata), .out_eop(oeop), .out_ready(ordy),
        .link_up(link),
        .tbl_we(twe), .tbl_addr(taddr), .tbl_mask(tmask), .tbl_strip(tstrip),
        .drop_count(dcnt)
    );

    always @(posedge clk) begin
        #1;
        for (int o = 0; o < NP; o++) rnd_bits[o] = ($urandom % 4) != 0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int o = 0; o < NP; o++) begin
                if (ovalid[o] && ordy[o]) rxq[o].push_back({oeop[o], odata[o*8 +: 8]});
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(logic [7:0] base, int k);
        return 8'(int'(base) + k * 29);
    endfunction

    task automatic exp_pkt(int dest, logic [7:0] hdr, int n, logic [7:0] base, logic strip);
        if (!strip || n == 0) exq[dest].push_back({n == 0, hdr});
        for (int k = 0; k < n; k++) exq[dest].push_back({k == n - 1, pay(base, k)});
    endtask

    task automatic xfer(int i, logic [7:0] b, logic e);
        vin[i] = 1'b1;
        din[i*8 +: 8] = b;
        ein[i] = e;
        @(negedge clk);
        while (!irdy[i]) @(negedge clk);
        @(posedge clk);
        #1;
        vin[i] = 1'b0;
    endtask

    task automatic send_pkt(int i, logic [7:0] hdr, int n, logic [7:0] base);
        xfer(i, hdr, n == 0);
        for (int k = 0; k < n; k++) xfer(i, pay(base, k), k == n - 1);
    endtask

    task automatic tw(logic [7:0] a, logic [NP-1:0] m, logic s);
        twe = 1'b1; taddr = a; tmask = m; tstrip = s;
        @(posedge clk);
        #1;
        twe = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic compare(string tag);
        for (int o = 0; o < NP; o++) begin
            chk($sformatf("%s port %0d count", tag, o), rxq[o].size(), exq[o].size());
            for (int k = 0; k < rxq[o].size() && k < exq[o].size(); k++) begin
                chk($sformatf("%s port %0d byte %0d", tag, o, k), rxq[o][k], exq[o][k]);
            end
            rxq[o].delete();
            exq[o].delete();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", ovalid, 0);
        chk("R10 in_ready", irdy, 0);
        chk("R10 drop_count", dcnt, 0);
        @(posedge clk);
        #1;

        // R1 direct address, header stripped
        exp_pkt(3, 8'd3, 4, 8'h10, 1'b1);
        send_pkt(0, 8'd3, 4, 8'h10);
        settle();
        compare("R1 direct");

        // R2 R3 logical lookup, header kept, lowest member
        tw(8'd40, 8'b0010_0100, 1'b0);
        exp_pkt(2, 8'd40, 3, 8'h30, 1'b0);
        send_pkt(1, 8'd40, 3, 8'h30);
        settle();
        compare("R2 R3 logical");

        // R4 failover to other group member
        link[2] = 1'b0;
        exp_pkt(5, 8'd40, 3, 8'h50, 1'b0);
        send_pkt(1, 8'd40, 3, 8'h50);
        settle();
        compare("R4 failover");
        link[2] = 1'b1;

        // R8 R5 R3 group fully busy
        xfer(0, 8'd40, 1'b0);
        xfer(0, 8'h11, 1'b0);
        xfer(1, 8'd40, 1'b0);
        xfer(1, 8'h22, 1'b0);
        fork
            begin
                send_pkt(2, 8'd40, 2, 8'h70);
            end
        join_none
        repeat (5) @(negedge clk);
        chk("R8 waiting in_ready", irdy[2], 0);
        chk("R5 port2 held bytes", rxq[2].size(), 2);
        chk("R3 R5 port5 held bytes", rxq[5].size(), 2);
        @(posedge clk);
        #1;
        xfer(0, 8'h12, 1'b1);
        xfer(1, 8'h23, 1'b1);
        wait fork;
        settle();
        exq[2].push_back({1'b0, 8'd40});
        exq[2].push_back({1'b0, 8'h11});
        exq[2].push_back({1'b1, 8'h12});
        exp_pkt(2, 8'd40, 2, 8'h70, 1'b0);
        exq[5].push_back({1'b0, 8'd40});
        exq[5].push_back({1'b0, 8'h22});
        exq[5].push_back({1'b1, 8'h23});
        compare("R8 R5 busy group");

        // R6 round robin on a single-member group
        tw(8'd50, 8'b0100_0000, 1'b1);
        exp_pkt(6, 8'd50, 1, 8'hA1, 1'b1);
        send_pkt(1, 8'd50, 1, 8'hA1);
        settle();
        exp_pkt(6, 8'd50, 1, 8'hA2, 1'b1);
        exp_pkt(6, 8'd50, 1, 8'hA0, 1'b1);
        exp_pkt(6, 8'd50, 1, 8'hA1, 1'b1);
        fork
            send_pkt(0, 8'd50, 1, 8'hA0);
            send_pkt(1, 8'd50, 1, 8'hA1);
            send_pkt(2, 8'd50, 1, 8'hA2);
        join
        settle();
        compare("R6 round robin");

        // R7 discard cases
        send_pkt(3, 8'd60, 3, 8'h90);
        settle();
        chk("R7 empty entry count", dcnt, 1);
        link[2] = 1'b0;
        link[5] = 1'b0;
        send_pkt(3, 8'd40, 2, 8'h91);
        settle();
        chk("R7 group down count", dcnt, 2);
        link = '1;
        fork
            send_pkt(3, 8'd20, 2, 8'h92);
            send_pkt(4, 8'd61, 0, 8'h93);
            begin
                @(posedge clk);
                #1;
                chk("R7 same-cycle drops", dcnt, 4);
            end
        join
        exp_pkt(1, 8'd1, 2, 8'h94, 1'b1);
        send_pkt(3, 8'd1, 2, 8'h94);
        settle();
        chk("R7 final count", dcnt, 4);
        compare("R7 nothing leaked, recovery");

        // R9 write into direct range ignored
        tw(8'd5, 8'b0000_0001, 1'b0);
        exp_pkt(5, 8'd5, 2, 8'hC0, 1'b1);
        send_pkt(2, 8'd5, 2, 8'hC0);
        settle();
        compare("R9 direct write ignored");

        // R11 backpressure
        man_rdy[4] = 1'b0;
        exp_pkt(4, 8'd4, 3, 8'hD0, 1'b1);
        fork
            begin
                send_pkt(0, 8'd4, 3, 8'hD0);
            end
        join_none
        repeat (4) @(negedge clk);
        chk("R11 out_valid held", ovalid[4], 1);
        chk("R11 out_data held", odata[4*8 +: 8], 8'hD0);
        chk("R11 in_ready low", irdy[0], 0);
        @(posedge clk);
        #1;
        man_rdy[4] = 1'b1;
        wait fork;
        settle();
        compare("R11 backpressure");

        // R1 R11 random parallel traffic with random output stalls
        rand_rdy = 1'b1;
        for (int r = 0; r < 12; r++) begin
            automatic int sh = 1 + int'($urandom % (NP - 1));
            for (int i = 0; i < NP; i++) begin
                automatic int ii = i;
                automatic int dst = (i + sh) % NP;
                automatic int nn = int'($urandom % 6);
                automatic logic [7:0] bb = 8'($urandom);
                exp_pkt(dst, 8'(dst), nn, bb, 1'b1);
                fork
                    send_pkt(ii, 8'(dst), nn, bb);
                join_none
            end
            wait fork;
            settle();
            compare("R1 R11 random");
        end
        rand_rdy = 1'b0;

        // R9 R10 reset empties the table
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R10 count after reset", dcnt, 0);
        @(posedge clk);
        #1;
        send_pkt(0, 8'd40, 1, 8'hE0);
        settle();
        chk("R9 cleared entry drops", dcnt, 1);
        compare("R9 cleared entry");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule